// File: doc/BRIEF.md
# Quadrant Pixel Tagger with Per-Line Dark Clamp

This block sits directly after the converter on one output of a four-output full-frame CCD. It receives the quadrant's digitized samples as a valid/ready stream. Two markers travel with the samples: one flags the first sample of a frame and one flags the last sample of a line. The block works out where each sample lies in the line and in the frame, and it labels the sample as one of four classes: a leading dummy sample, a masked dark-reference column, a photoactive sample, or part of a masked dark line.

On every line, the masked columns arrive ahead of the photoactive columns. Their average gives the black level for that same line. The average uses a power-of-two sample count, so the division is a right shift. The black level is subtracted from each photoactive sample and the result is clamped at zero. Only photoactive samples of image lines leave the block, and the last one of each line carries an end marker.

A control pin lets the host drop the dark columns nearest the image area, because those columns can collect stray signal. A line that ends early raises a one-cycle error pulse, and position counting restarts on the following line.

Back-pressure works as follows. The output is a single register stage. `s_ready` is high when that stage is empty or is being drained in the same cycle (`m_ready` high). A sample is taken in when `s_valid` and `s_ready` are both high. While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` do not change. Samples that are not emitted still need `s_ready` to be accepted.

Top module: `ccd_quad_tagger`

## Requirements
- R1: `in_class` gives the class of the sample currently on `s_data`: 0 = dummy for line positions 1 to 4, 1 = dark reference for positions 5 to 8, 2 = active for positions 9 to LINE_LEN (default 1050), and 3 = dark line for every position of lines 0 to 3 of a frame. Class 3 takes priority over the other classes.
- R2: A sample accepted with `s_sof` high is position 1 of line 0, whatever the counters held before.
- R3: After position LINE_LEN the next sample is position 1 of the next line, even without `s_eol`. After line LINES-1 (default 1045, so 1046 lines) the line count returns to 0 without `s_sof`.
- R4: With `skip_edge` low, the black level of a line is the sum of positions 5 to 8 shifted right by 2.
- R5: With `skip_edge` high when position 1 is accepted, only positions 5 and 6 are used for that line, shifted right by 1, so the two columns nearest the image area have no effect.
- R6: The values of dummy samples (positions 1 to 4) have no effect on any output.
- R7: Each emitted value is the input sample minus the black level of its own line, or 0 when the sample is at or below that level.
- R8: Exactly one output word is produced for each accepted active-class sample, and none for any other class.
- R9: `m_last` is high on the word from position LINE_LEN, and on the word from an active sample accepted with `s_eol`. It is low on all other words.
- R10: A sample accepted with `s_eol` at a position other than LINE_LEN makes `err_short` high for the following cycle, and the next sample is position 1 of the next line.
- R11: `s_ready` is high exactly when `m_valid` is low or `m_ready` is high. A stalled output word holds its data and marker.
- R12: After reset, `m_valid` and `err_short` are low and the counters point at position 1 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | W (16) | Digitized sample |
| s_sof | input | 1 | Sample is the first of a frame |
| s_eol | input | 1 | Sample is the last of its line |
| skip_edge | input | 1 | Leave out the dark columns nearest the image area |
| in_class | output | 2 | Class of the sample on `s_data` |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream takes the word |
| m_data | output | W (16) | Black-corrected active sample |
| m_last | output | 1 | Last active word of the line |
| err_short | output | 1 | Line ended early, one-cycle pulse |

## Verification
The bench uses input values below the black level so that the clamp must produce zero. A design that subtracted without clamping would return a large wrapped value there.

The bench sets the nearest dark columns far above the other dark columns. A design that ignored `skip_edge` would then produce a black level many times too high. It also sends the same line twice with extreme dummy values. A design that mixed dummy samples into the average would give two different outputs for these lines.

A short line, a line that runs past its length with no end marker, and a wrap past the final line of a frame all check the position counters. Counters that drifted would misclassify the following line or drop its end marker. A stall in the middle of a line checks that a held word neither changes nor swallows the next sample.

// File: rtl/ccd_tag_pkg.sv
package ccd_tag_pkg;
  typedef enum logic [1:0] {
    PX_DUMMY    = 2'd0,
    PX_DARKREF  = 2'd1,
    PX_ACTIVE   = 2'd2,
    PX_DARKLINE = 2'd3
  } px_class_e;
endpackage

// File: rtl/ccd_pos_track.sv
module ccd_pos_track #(
  parameter int LINE_LEN = 1050,
  parameter int LINES    = 1046,
  parameter int COL_W    = $clog2(LINE_LEN + 1),
  parameter int ROW_W    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             sof,
  input  logic             eol,
  output logic [COL_W-1:0] eff_col,
  output logic [ROW_W-1:0] eff_row,
  output logic             err_short
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_LEN);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(LINES - 1);

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             line_end;

  // A frame marker overrides whatever the counters hold.
  always_comb begin
    eff_col  = sof ? COL_W'(1) : col_q;
    eff_row  = sof ? '0 : row_q;
    line_end = eol || (eff_col == LAST_COL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q     <= COL_W'(1);
      row_q     <= '0;
      err_short <= 1'b0;
    end else begin
      err_short <= adv && eol && (eff_col != LAST_COL);
      if (adv) begin
        if (line_end) begin
          col_q <= COL_W'(1);
          row_q <= (eff_row == LAST_ROW) ? '0 : eff_row + 1'b1;
        end else begin
          col_q <= eff_col + 1'b1;
          row_q <= eff_row;
        end
      end
    end
  end
endmodule

// File: rtl/ccd_dark_avg.sv
module ccd_dark_avg #(
  parameter int W       = 16,
  parameter int DUMMY_N = 4,
  parameter int DARK_N  = 4,
  parameter int COL_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [COL_W-1:0] col,
  input  logic             skip,
  input  logic [W-1:0]     data,
  output logic [W-1:0]     black
);
  localparam int SH    = $clog2(DARK_N);
  localparam int SUM_W = W + SH;
  localparam logic [COL_W-1:0] FIRST_COL = COL_W'(DUMMY_N + 1);
  localparam logic [COL_W-1:0] LAST_FULL = COL_W'(DUMMY_N + DARK_N);
  localparam logic [COL_W-1:0] LAST_HALF = COL_W'(DUMMY_N + DARK_N / 2);

  logic             skip_q;
  logic             skip_eff;
  logic [COL_W-1:0] last_sel;
  logic             in_sel;
  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] acc_next;

  always_comb begin
    skip_eff = (col == COL_W'(1)) ? skip : skip_q;
    last_sel = skip_eff ? LAST_HALF : LAST_FULL;
    in_sel   = (col >= FIRST_COL) && (col <= last_sel);
    acc_next = acc + SUM_W'(data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_q <= 1'b0;
      acc    <= '0;
      black  <= '0;
    end else if (adv) begin
      if (col == COL_W'(1)) begin
        skip_q <= skip;
        acc    <= '0;
      end else if (in_sel) begin
        acc <= acc_next;
        if (col == last_sel)
          black <= skip_eff ? W'(acc_next >> (SH - 1)) : W'(acc_next >> SH);
      end
    end
  end
endmodule

// File: rtl/ccd_clamp_out.sv
module ccd_clamp_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic [W-1:0] black,
  input  logic         last_in,
  input  logic         m_ready,
  output logic         m_valid,
  output logic [W-1:0] m_data,
  output logic         m_last
);
  logic [W-1:0] diff;

  always_comb diff = (data > black) ? data - black : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= diff;
      m_last  <= last_in;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ccd_quad_tagger.sv
module ccd_quad_tagger
  import ccd_tag_pkg::*;
#(
  parameter int W          = 16,
  parameter int LINE_LEN   = 1050,
  parameter int LINES      = 1046,
  parameter int DUMMY_N    = 4,
  parameter int DARK_N     = 4,
  parameter int DARK_LINES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  input  logic         s_sof,
  input  logic         s_eol,
  input  logic         skip_edge,
  output logic [1:0]   in_class,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data,
  output logic         m_last,
  output logic         err_short
);
  localparam int COL_W = $clog2(LINE_LEN + 1);
  localparam int ROW_W = $clog2(LINES);
  localparam logic [COL_W-1:0] DUMMY_END = COL_W'(DUMMY_N);
  localparam logic [COL_W-1:0] DARK_END  = COL_W'(DUMMY_N + DARK_N);
  localparam logic [COL_W-1:0] LAST_COL  = COL_W'(LINE_LEN);
  localparam logic [ROW_W-1:0] DARK_ROWS = ROW_W'(DARK_LINES);

  logic [COL_W-1:0] eff_col;
  logic [ROW_W-1:0] eff_row;
  logic [W-1:0]     black;
  logic             adv;
  logic             load;
  px_class_e        cls;

  always_comb begin
    s_ready = !m_valid || m_ready;
    adv     = s_valid && s_ready;
    if (eff_row < DARK_ROWS)       cls = PX_DARKLINE;
    else if (eff_col <= DUMMY_END) cls = PX_DUMMY;
    else if (eff_col <= DARK_END)  cls = PX_DARKREF;
    else                           cls = PX_ACTIVE;
    in_class = cls;
    load     = adv && (cls == PX_ACTIVE);
  end

  ccd_pos_track #(
    .LINE_LEN(LINE_LEN), .LINES(LINES), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(adv), .sof(s_sof), .eol(s_eol),
    .eff_col(eff_col), .eff_row(eff_row), .err_short(err_short)
  );

  ccd_dark_avg #(
    .W(W), .DUMMY_N(DUMMY_N), .DARK_N(DARK_N), .COL_W(COL_W)
  ) u_dark (
    .clk(clk), .rst_n(rst_n), .adv(adv), .col(eff_col), .skip(skip_edge),
    .data(s_data), .black(black)
  );

  ccd_clamp_out #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .data(s_data), .black(black),
    .last_in(s_eol || (eff_col == LAST_COL)), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data), .m_last(m_last)
  );
endmodule

// File: rtl/ccd_quad_tagger_chk.sv
module ccd_quad_tagger_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         s_valid,
  input logic         s_ready,
  input logic         s_eol,
  input logic [1:0]   in_class,
  input logic         m_valid,
  input logic         m_ready,
  input logic [W-1:0] m_data,
  input logic         m_last,
  input logic         err_short
);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

  // R8
  no_emit_nonactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && in_class != 2'd2 |=> !m_valid);

  // R8
  emit_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(s_valid && s_ready && in_class == 2'd2));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_short |-> $past(s_valid && s_ready && s_eol));
endmodule

bind ccd_quad_tagger ccd_quad_tagger_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_eol(s_eol), .in_class(in_class), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_last(m_last), .err_short(err_short)
);

// File: tb/tb_ccd_quad_tagger.sv
module tb_ccd_quad_tagger;
  localparam int CLK_P = 10;
  localparam int W     = 16;
  localparam int LLEN  = 20;
  localparam int NLIN  = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [W-1:0] s_data = '0;
  logic         s_sof = 1'b0;
  logic         s_eol = 1'b0;
  logic         skip_edge = 1'b0;
  logic [1:0]   in_class;
  logic         m_valid;
  logic         m_ready = 1'b1;
  logic [W-1:0] m_data;
  logic         m_last;
  logic         err_short;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ccd_quad_tagger #(.W(W), .LINE_LEN(LLEN), .LINES(NLIN)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eol(s_eol), .skip_edge(skip_edge),
    .in_class(in_class), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last), .err_short(err_short)
  );

  task automatic chk(input bit ok, input string r, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  function automatic int pix_val(input int p, input int abase);
    return (abase + (p - 9) * 53) % 65536;
  endfunction

  function automatic int black_of(input bit skip, input int d0, input int d1,
                                  input int d2, input int d3);
    return skip ? (d0 + d1) / 2 : (d0 + d1 + d2 + d3) / 4;
  endfunction

  // One sample: drive at negedge, check class before the edge, outputs after it.
  task automatic send_px(input int val, input bit sof, input bit eol,
                         input int ecls, input bit evalid, input int edata,
                         input bit elast, input bit eerr, input string r);
    @(negedge clk);
    s_valid = 1'b1; s_data = W'(val); s_sof = sof; s_eol = eol;
    #1;
    chk(in_class == 2'(ecls), r, "in_class", int'(in_class), ecls);
    @(posedge clk);
    #2;
    s_valid = 1'b0; s_sof = 1'b0; s_eol = 1'b0;
    chk(m_valid == evalid, r, "m_valid", int'(m_valid), int'(evalid));
    if (evalid) begin
      chk(m_data == W'(edata), r, "m_data", int'(m_data), edata);
      chk(m_last == elast, r, "m_last", int'(m_last), int'(elast));
    end
    chk(err_short == eerr, r, "err_short", int'(err_short), int'(eerr));
  endtask

  task automatic send_line(input int p0, input int pend, input bit first,
                           input bit dark, input bit skip, input bit use_eol,
                           input int d0, input int d1, input int d2, input int d3,
                           input int dum, input int abase, input string r);
    int blk;
    blk = black_of(skip, d0, d1, d2, d3);
    skip_edge = skip;
    for (int p = p0; p <= pend; p++) begin
      int v, ec, ed;
      bit ev, el, ee, eo;
      eo = use_eol && (p == pend);
      if (p <= 4) v = dum;
      else if (p == 5) v = d0;
      else if (p == 6) v = d1;
      else if (p == 7) v = d2;
      else if (p == 8) v = d3;
      else v = pix_val(p, abase);
      ec = dark ? 3 : (p <= 4 ? 0 : (p <= 8 ? 1 : 2));
      ev = !dark && p >= 9;
      ed = (v > blk) ? v - blk : 0;
      el = ev && (eo || p == LLEN);
      ee = eo && (p != LLEN);
      send_px(v, first && p == p0, eo, ec, ev, ed, el, ee, r);
    end
  endtask

  task automatic dark_lines(input bit first);
    for (int l = 0; l < 4; l++)
      send_line(1, LLEN, first && l == 0, 1'b1, 1'b0, 1'b1,
                900, 900, 900, 900, 7, 3000, "R1");
  endtask

  task automatic t_reset;
    chk(m_valid == 1'b0, "R12", "m_valid", int'(m_valid), 0);
    chk(err_short == 1'b0, "R12", "err_short", int'(err_short), 0);
    chk(s_ready == 1'b1, "R12", "s_ready", int'(s_ready), 1);
    // R12: first sample after reset is line 0, so it is a dark-line sample
    send_px(5000, 1'b0, 1'b0, 3, 1'b0, 0, 1'b0, 1'b0, "R12");
  endtask

  task automatic t_frame_basic;
    // R2 R1 R4 R7 R8 R9
    dark_lines(1'b1);
    send_line(1, LLEN, 1'b0, 1'b0, 1'b0, 1'b1, 100, 104, 108, 112, 11, 50, "R7");
    send_line(1, LLEN, 1'b0, 1'b0, 1'b0, 1'b1, 400, 420, 380, 440, 11, 2000, "R4");
  endtask

  task automatic t_skip;
    // R5: nearest columns far above, excluded when skip_edge is high
    dark_lines(1'b1);
    send_line(1, LLEN, 1'b0, 1'b0, 1'b1, 1'b1, 200, 202, 9000, 9000, 3, 300, "R5");
    send_line(1, LLEN, 1'b0, 1'b0, 1'b0, 1'b1, 200, 202, 9000, 9000, 3, 5000, "R4");
  endtask

  task automatic t_dummy;
    // R6: identical lines apart from extreme dummy values
    dark_lines(1'b1);
    send_line(1, LLEN, 1'b0, 1'b0, 1'b0, 1'b1, 300, 300, 300, 300, 0, 700, "R6");
    send_line(1, LLEN, 1'b0, 1'b0, 1'b0, 1'b1, 300, 300, 300, 300, 65535, 700, "R6");
  endtask

  task automatic t_short;
    // R10: line ends at position 12, next line restarts at position 1
    dark_lines(1'b1);
    send_line(1, 12, 1'b0, 1'b0, 1'b0, 1'b1, 100, 100, 100, 100, 1, 800, "R10");
    send_line(1, LLEN, 1'b0, 1'b0, 1'b0, 1'b1, 120, 120, 120, 120, 1, 900, "R10");
    // R10: a short dark line also flags the error
    send_line(1, 6, 1'b1, 1'b1, 1'b0, 1'b1, 1, 1, 1, 1, 1, 1, "R10");
  endtask

  task automatic t_wrap;
    // R3: lines with no end marker, then a wrap back to line 0 without a frame marker
    dark_lines(1'b1);
    for (int l = 0; l < 4; l++)
      send_line(1, LLEN, 1'b0, 1'b0, 1'b0, 1'b0, 60, 64, 68, 72, 9, 100 + l * 10, "R3");
    send_line(1, LLEN, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0, 0, 0, 9, 100, "R3");
  endtask

  task automatic t_stall;
    int blk, v9, v10;
    // R11
    dark_lines(1'b1);
    send_line(1, 8, 1'b0, 1'b0, 1'b0, 1'b0, 40, 40, 40, 40, 2, 0, "R11");
    blk = 40;
    v9  = pix_val(9, 1000);
    v10 = pix_val(10, 1000);
    m_ready = 1'b0;
    send_px(v9, 1'b0, 1'b0, 2, 1'b1, v9 - blk, 1'b0, 1'b0, "R11");
    @(negedge clk);
    s_valid = 1'b1; s_data = W'(v10);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(s_ready == 1'b0, "R11", "s_ready stalled", int'(s_ready), 0);
      chk(m_valid && m_data == W'(v9 - blk), "R11", "held m_data",
          int'(m_data), v9 - blk);
      @(negedge clk);
    end
    m_ready = 1'b1;
    #1;
    chk(s_ready == 1'b1, "R11", "s_ready released", int'(s_ready), 1);
    @(posedge clk);
    #2;
    s_valid = 1'b0;
    chk(m_valid && m_data == W'(v10 - blk), "R11", "next word",
        int'(m_data), v10 - blk);
    send_line(11, LLEN, 1'b0, 1'b0, 1'b0, 1'b1, 40, 40, 40, 40, 2, 1000, "R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    #1;
    t_reset();
    t_frame_basic();
    t_skip();
    t_dummy();
    t_short();
    t_wrap();
    t_stall();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule